// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block deserialises a stereo audio stream carried on three wires (a bit clock, a channel-select clock and a data line) into parallel left and right words. All three serial inputs are sampled by the system clock `clk`, which must run at least four times faster than the bit clock. Edges of the bit clock are found by comparing each sample with the one before it. A 3-bit selector chooses one of seven framings: right-aligned words of 16, 18 or 20 bits; 20-bit words aligned to the start of the channel period, latched on either bit-clock edge; and a one-bit-delayed framing with inverted channel polarity at 16 or 20 bits.

Each received word is sign-extended to the output width. Once both channel words of a frame have arrived, they are presented together with a single-cycle strobe. The reserved selector value is not decoded as audio. Instead it raises a calibration request towards the analog side. The selector is sampled only when a frame starts, so changing it mid-frame never corrupts the frame in flight.

Top module: `aud_serial_rx`

## Requirements
- R1: While `rst_n` is low, `left_o`, `right_o`, `pair_valid` and `cal_req` are all 0.
- R2: Selector 0, 1 or 2 gives a right-aligned word of 16, 18 or 20 bits, latched on bit-clock rising edges. The word is the last N bits latched before the channel-clock transition that ends the channel period. Bits latched earlier in that period are ignored.
- R3: Selector 3 or 4 gives a 20-bit word made of the first 20 bits latched after the channel-clock transition. Selector 3 latches on bit-clock falling edges and selector 4 on rising edges. Later bits in the period are ignored, so shorter words padded with trailing zeros come out as 20-bit values.
- R4: Selector 5 or 6 latches on bit-clock rising edges. The first bit after the channel-clock transition is skipped and the next 16 (selector 5) or 20 (selector 6) bits form the word. A low channel clock marks the left channel.
- R5: For selectors 0 to 4 and 7, a high channel clock marks the left channel and a low one the right channel.
- R6: `cal_req` equals (selector == 7) as sampled one clock earlier. A frame that begins while the selector is 7 produces no strobe.
- R7: `pair_valid` is high for exactly one cycle, in the cycle after the channel-clock edge that starts the next frame's left period. In that cycle `left_o` and `right_o` hold the two words of the frame that just ended.
- R8: Words are two's complement and arrive MSB first. 16- and 18-bit words are sign-extended to 20 bits.
- R9: The selector is sampled at the channel-clock edge that starts a left period. A change during a frame applies from the next frame.
- R10: After reset, the first strobe comes only once a complete left and right period have both been received. The partial period before the first observed channel-clock edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| bck | input | 1 | Serial bit clock |
| lrck | input | 1 | Channel-select clock |
| sdata | input | 1 | Serial data, MSB first |
| fmt_sel | input | 3 | Framing selector, 7 requests calibration |
| left_o | output | DW | Left sample, sign-extended |
| right_o | output | DW | Right sample, sign-extended |
| pair_valid | output | 1 | One-cycle strobe for a new sample pair |
| cal_req | output | 1 | Calibration request (selector 7) |

## Verification
A wrong bit counter or window shows at the next strobe, about one frame later, as a word shifted by one or more bit positions. Leading filler bits of all ones make that shift visible at once. A wrong captured format or channel polarity shows as swapped channels, as filler ones in the upper bits, or as a missing or extra strobe. Each of these is caught at the first frame boundary after the fault. A wrong calibration flag shows within one clock of the selector change.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int OUT_W = 20;

  typedef enum logic [2:0] {
    FMT_RJ16    = 3'd0,
    FMT_RJ18    = 3'd1,
    FMT_RJ20    = 3'd2,
    FMT_LJ_FALL = 3'd3,
    FMT_LJ_RISE = 3'd4,
    FMT_DLY16   = 3'd5,
    FMT_DLY20   = 3'd6,
    FMT_CAL     = 3'd7
  } fmt_e;

  // number of significant bits carried by one channel word
  function automatic int word_bits(fmt_e f, int dw);
    case (f)
      FMT_RJ16, FMT_DLY16: return dw - 4;
      FMT_RJ18:            return dw - 2;
      default:             return dw;
    endcase
  endfunction

  function automatic logic is_rj(fmt_e f);
    return (f == FMT_RJ16) || (f == FMT_RJ18) || (f == FMT_RJ20);
  endfunction

  // one-bit-delayed framing with inverted channel polarity
  function automatic logic is_dly(fmt_e f);
    return (f == FMT_DLY16) || (f == FMT_DLY20);
  endfunction

  function automatic logic latch_on_fall(fmt_e f);
    return f == FMT_LJ_FALL;
  endfunction

endpackage

// File: rtl/aud_rx_edges.sv
module aud_rx_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic bck,
  input  logic lrck,
  output logic bck_rise,
  output logic bck_fall,
  output logic lr_chg
);
  logic bck_q, lr_q, primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_q  <= 1'b0;
      lr_q   <= 1'b0;
      primed <= 1'b0;
    end else begin
      bck_q  <= bck;
      lr_q   <= lrck;
      primed <= 1'b1;
    end
  end

  // no edges are reported until one valid history sample exists
  assign bck_rise = primed & bck & ~bck_q;
  assign bck_fall = primed & ~bck & bck_q;
  assign lr_chg   = primed & (lrck ^ lr_q);
endmodule

// File: rtl/aud_rx_shift.sv
module aud_rx_shift
  import aud_rx_pkg::*;
#(
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          latch,
  input  logic          sd,
  input  fmt_e          fmt,
  output logic [DW-1:0] shreg
);
  localparam int CW = $clog2(DW + 2) + 1;

  logic [CW-1:0] cnt;
  int            off, nb;
  logic          take;

  always_comb begin
    off = is_dly(fmt) ? 1 : 0;
    nb  = word_bits(fmt, DW);
    // right-aligned formats shift every bit, the low bits keep the newest
    take = is_rj(fmt) || ((int'(cnt) >= off) && (int'(cnt) < off + nb));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (restart) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (latch) begin
      if (cnt != '1) cnt <= cnt + 1'b1;
      if (take) shreg <= {shreg[DW-2:0], sd};
    end
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int DW = aud_rx_pkg::OUT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bck,
  input  logic          lrck,
  input  logic          sdata,
  input  logic [2:0]    fmt_sel,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          pair_valid,
  output logic          cal_req
);
  logic          bck_rise, bck_fall, lr_chg;
  logic          latch, lr_left_now, frame_start;
  logic          armed, have_left;
  fmt_e          fmt_act;
  logic [DW-1:0] shreg, left_hold, word_done;

  function automatic logic [DW-1:0] sext(input logic [DW-1:0] raw, input int n);
    logic [DW-1:0] r;
    logic          sb;
    sb = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i == n - 1) sb = raw[i];
    r = raw;
    for (int i = 0; i < DW; i++)
      if (i >= n) r[i] = sb;
    return r;
  endfunction

  aud_rx_edges u_edges (
    .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck),
    .bck_rise(bck_rise), .bck_fall(bck_fall), .lr_chg(lr_chg)
  );

  assign latch       = latch_on_fall(fmt_act) ? bck_fall : bck_rise;
  assign lr_left_now = is_dly(fmt_act) ? ~lrck : lrck;
  assign frame_start = lr_chg & lr_left_now;
  assign word_done   = sext(shreg, word_bits(fmt_act, DW));

  aud_rx_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .restart(lr_chg), .latch(latch),
    .sd(sdata), .fmt(fmt_act), .shreg(shreg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_act    <= FMT_RJ16;
      armed      <= 1'b0;
      have_left  <= 1'b0;
      left_hold  <= '0;
      left_o     <= '0;
      right_o    <= '0;
      pair_valid <= 1'b0;
      cal_req    <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      cal_req    <= (fmt_sel == 3'd7);
      if (!armed || frame_start) fmt_act <= fmt_e'(fmt_sel);
      if (lr_chg) armed <= 1'b1;
      if (lr_chg && armed) begin
        if (!lr_left_now) begin
          left_hold <= word_done;
          have_left <= 1'b1;
        end else begin
          have_left <= 1'b0;
          if (have_left && fmt_act != FMT_CAL) begin
            left_o     <= left_hold;
            right_o    <= word_done;
            pair_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int DW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    fmt_sel,
  input logic [2:0]    fmt_act,
  input logic          frame_start,
  input logic          armed,
  input logic [DW-1:0] left_o,
  input logic          pair_valid,
  input logic          cal_req
);
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  p_pulse_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(frame_start));

  p_cal_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cal_req == ($past(fmt_sel) == 3'd7)));

  p_no_pair_cal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> ($past(fmt_act) != 3'd7));

  p_fmt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !frame_start) |=> $stable(fmt_act));

  p_sext16_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && ($past(fmt_act) == 3'd0 || $past(fmt_act) == 3'd5))
      |-> (left_o[DW-1:DW-5] == {5{left_o[DW-5]}}));
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .fmt_act(fmt_act),
  .frame_start(frame_start), .armed(armed), .left_o(left_o),
  .pair_valid(pair_valid), .cal_req(cal_req)
);

// File: tb/sim_aud_serial_rx.sv
module sim_aud_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n, bck, lrck, sdata;
  logic [2:0]  fmt_sel;
  logic [19:0] left_o, right_o;
  logic        pair_valid, cal_req;

  int checks = 0, fails = 0, pulses = 0, exp_pulses = 0;
  bit done = 0;
  bit pv;
  logic [19:0] pl, pr;
  string ptag;

  always #5 clk = ~clk;

  aud_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck), .sdata(sdata),
    .fmt_sel(fmt_sel), .left_o(left_o), .right_o(right_o),
    .pair_valid(pair_valid), .cal_req(cal_req)
  );

  // every-clock monitor of strobes
  always @(negedge clk) if (rst_n === 1'b1 && pair_valid === 1'b1) pulses++;

  task automatic chk(string tag, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int wbits(int f);
    if (f == 0 || f == 5) return 16;
    if (f == 1) return 18;
    return 20;
  endfunction

  function automatic bit dly(int f);
    return f == 5 || f == 6;
  endfunction

  function automatic logic [19:0] expect_of(int f, int w);
    int n = wbits(f);
    longint v = longint'(w) & ((longint'(1) << n) - 1);
    if (v >= (longint'(1) << (n - 1))) v = v - (longint'(1) << n);
    return v[19:0];
  endfunction

  // bit on the wire in a given slot; filler slots carry ones
  function automatic logic txbit(int f, int w, int slot);
    int n = wbits(f);
    if (f <= 2 || f == 7) begin
      if (slot >= 32 - n) return w[n - 1 - (slot - (32 - n))];
      return 1'b1;
    end
    if (f == 3 || f == 4) begin
      if (slot < 20) return w[19 - slot];
      return 1'b1;
    end
    if (slot >= 1 && slot <= n) return w[n - slot];
    return 1'b1;
  endfunction

  task automatic half(int f, bit left, int w, int mid);
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      bck   = (f == 3);
      sdata = txbit(f, w, s);
      if (s == 0) begin
        lrck = left ? !dly(f) : dly(f);
        if (left) fmt_sel = 3'(f);
      end
      if (left && s == 10 && mid >= 0) fmt_sel = 3'(mid);
      @(negedge clk);
      if (left && s == 0) begin
        chk({"R7 strobe ", ptag}, {19'd0, pair_valid}, {19'd0, pv});
        if (pv) begin
          chk({"left ", ptag}, left_o, pl);
          chk({"right ", ptag}, right_o, pr);
        end
        chk("R6 cal_req", {19'd0, cal_req}, {19'd0, f == 7});
      end
      @(negedge clk);
      bck = (f != 3);
      @(negedge clk);
    end
  endtask

  task automatic frame(int f, int l, int r, string tag, int mid = -1);
    half(f, 1'b1, l, mid);
    half(f, 1'b0, r, -1);
    pv   = (f != 7);
    pl   = expect_of(f, l);
    pr   = expect_of(f, r);
    ptag = tag;
    if (pv) exp_pulses++;
  endtask

  task automatic group_reset(int f);
    rst_n   = 1'b0;
    fmt_sel = 3'(f);
    bck     = (f != 3);
    lrck    = dly(f);
    sdata   = 1'b0;
    pv      = 1'b0;
    ptag    = "R10 first";
    repeat (3) @(negedge clk);
    chk("R1 valid", {19'd0, pair_valid}, 20'd0);
    chk("R1 left", left_o, 20'd0);
    chk("R1 right", right_o, 20'd0);
    chk("R1 cal", {19'd0, cal_req}, 20'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    group_reset(0);
    frame(0, 'h8001, 'h7FFE, "R2 R5 R8 rj16");
    frame(0, 'h00FF, 'hFF00, "R2 R5 R8 rj16");
    half(0, 1'b1, 0, -1);

    group_reset(1);
    frame(1, 'h20000, 'h1FFFF, "R2 R8 rj18");
    frame(1, 'h0ABCD, 'h3FFFF, "R2 R8 rj18");
    half(1, 1'b1, 0, -1);

    group_reset(2);
    frame(2, 'hABCDE, 'h12345, "R2 R5 rj20");
    half(2, 1'b1, 0, -1);

    group_reset(3);
    frame(3, 'h80000, 'h7FFFF, "R3 R5 lj fall");
    frame(3, 'h5A5A0, 'hA5A5A, "R3 R5 lj fall");
    half(3, 1'b1, 0, -1);

    group_reset(4);
    frame(4, 'h80000, 'h7FFFF, "R3 R5 lj rise");
    frame(4, 'h5A5A5, 'hA5A50, "R3 R5 lj rise");
    half(4, 1'b1, 0, -1);

    group_reset(5);
    frame(5, 'h8000, 'h0001, "R4 R8 dly16");
    frame(5, 'h7FFF, 'hC003, "R4 R8 dly16");
    half(5, 1'b1, 0, -1);

    group_reset(6);
    frame(6, 'hFFFFF, 'h00000, "R4 dly20");
    frame(6, 'h6789A, 'h98765, "R4 dly20");
    half(6, 1'b1, 0, -1);

    group_reset(0);
    frame(0, 'h1234, 'h0F0F, "R9 old fmt", 2);
    frame(2, 'h81234, 'h00001, "R9 new fmt");
    half(2, 1'b1, 0, -1);

    group_reset(0);
    frame(0, 'h4321, 'h8765, "R6 before");
    frame(7, 'h11111, 'h22222, "R6 cal");
    frame(7, 'h33333, 'h44444, "R6 cal");
    frame(0, 'h0042, 'hFFC0, "R6 after");
    half(0, 1'b1, 0, -1);

    chk("R7 strobe count", 20'(pulses), 20'(exp_pulses));
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule